// File: doc/BRIEF.md
# Processor-side interrupt acknowledge interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate as an identifier and a priority value. The block checks that candidate against an enable bit and a priority threshold, and drives a registered interrupt request to the processor. A real interrupt must also be the only one in service.

Software talks to the block over a small word-addressed register port. A read of the acknowledge register returns the winning identifier and claims it. The block then pulses a strobe so that the distributor can clear the pending state of an edge source, and it holds that interrupt in service. While one interrupt is in service nothing else is signalled. A write of the same identifier to the completion register ends the service period. When nothing qualifies, an acknowledge read returns the reserved spurious code 1023 and changes nothing.

Top module: `cpuif_ack`

## Requirements
- R1: After reset, `irq_o`, `bus_rdata_o`, `ack_strobe_o` and `eoi_strobe_o` are 0. The enable bit is 0, the threshold is 0 and no interrupt is in service.
- R2: `irq_o` is 1 in the cycle after a cycle in which all of these hold: the enable bit is 1, the candidate is valid, its priority is numerically below the threshold, its ID is below 1020, and nothing is in service.
- R3: A candidate whose priority value is equal to or above the threshold is not signalled.
- R4: With the enable bit (control register at word address 0, bit 0) cleared, `irq_o` stays 0 and an acknowledge read returns 1023.
- R5: A read at word address 2 (acknowledge) of a qualifying candidate puts its ID in `bus_rdata_o[9:0]` the next cycle, with all upper bits 0. In that same cycle `ack_strobe_o` pulses with `ack_id_o` equal to the ID.
- R6: An acknowledge read with no qualifying candidate returns 1023, gives no strobe and does not change the in-service state.
- R7: IDs 1020 to 1023 from the distributor are never signalled and never acknowledged.
- R8: After a successful acknowledge, `irq_o` is 0 in the next cycle and stays 0 until the matching completion write.
- R9: A write at word address 3 (completion) whose bits [9:0] equal the in-service ID ends service and pulses `eoi_strobe_o` with that ID the next cycle. After that a qualifying candidate is signalled again.
- R10: A completion write with any other ID, or with nothing in service, is ignored: no strobe, and the interrupt stays in service, so a later acknowledge read returns 1023.
- R11: The enable bit (word 0, bit 0) and the 8-bit threshold (word 1, bits [7:0]) read back what was written. Reads return data the cycle after the access; a read at word 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| bus_en_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_strobe_o | output | 1 | An interrupt was claimed |
| ack_id_o | output | 10 | ID of the claimed interrupt |
| eoi_strobe_o | output | 1 | An interrupt was completed |
| eoi_id_o | output | 10 | ID of the completed interrupt |

## Verification
A completion write and the arrival of a new qualifying candidate can fall in the same cycle. The bench provokes this by switching the candidate in the same cycle that it writes the matching completion ID. It then checks that the request rises only one cycle after service has ended, and that the strobe and the request never contradict the reference model. A threshold write that coincides with a candidate is also judged: the old threshold must apply in that cycle and the new one from the next cycle on.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_EOI  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpuif_regs.sv
module cpuif_regs #(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic              wr_mask_i,
  input  logic              ctrl_bit_i,
  input  logic [PRIO_W-1:0] mask_val_i,
  output logic              enable_o,
  output logic [PRIO_W-1:0] mask_o
);
  logic              en_d, en_q;
  logic [PRIO_W-1:0] mask_d, mask_q;

  always_comb begin
    en_d   = en_q;
    mask_d = mask_q;
    if (wr_ctrl_i) en_d   = ctrl_bit_i;
    if (wr_mask_i) mask_d = mask_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  assign enable_o = en_q;
  assign mask_o   = mask_q;

  // R11: a threshold write is visible the next cycle
  a_r11_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_o == $past(mask_val_i)));
endmodule

// File: rtl/cpuif_qualify.sv
module cpuif_qualify #(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input  logic              enable_i,
  input  logic              busy_i,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] mask_i,
  output logic              hit_o
);
  localparam logic [ID_W-1:0] FIRST_RSVD = ID_W'((1 << ID_W) - 4);

  logic id_ok, prio_ok;

  always_comb begin
    id_ok   = cand_id_i < FIRST_RSVD;
    prio_ok = cand_prio_i < mask_i;
    hit_o   = enable_i && cand_valid_i && id_ok && prio_ok && !busy_i;
  end
endmodule

// File: rtl/cpuif_active.sv
module cpuif_active #(
  parameter int ID_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [ID_W-1:0] take_id_i,
  input  logic            eoi_i,
  input  logic [ID_W-1:0] eoi_id_i,
  output logic            busy_o,
  output logic [ID_W-1:0] busy_id_o,
  output logic            retire_o
);
  logic            busy_d, busy_q;
  logic [ID_W-1:0] id_d, id_q;

  always_comb begin
    busy_d   = busy_q;
    id_d     = id_q;
    retire_o = eoi_i && busy_q && (eoi_id_i == id_q);
    if (retire_o) begin
      busy_d = 1'b0;
    end else if (take_i) begin
      busy_d = 1'b1;
      id_d   = take_id_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      id_q   <= '0;
    end else begin
      busy_q <= busy_d;
      id_q   <= id_d;
    end
  end

  assign busy_o    = busy_q;
  assign busy_id_o = id_q;

  // R8: a claim puts the ID in service
  a_r8_take_holds: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (busy_o && busy_id_o == $past(take_id_i)));

  // R10: a mismatched completion leaves service untouched
  a_r10_eoi_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && busy_o && eoi_id_i != busy_id_o) |=> (busy_o && $stable(busy_id_o)));
endmodule

// File: rtl/cpuif_ack.sv
module cpuif_ack
  import cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              ack_strobe_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_strobe_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  localparam logic [ID_W-1:0] SPURIOUS   = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] FIRST_RSVD = ID_W'((1 << ID_W) - 4);

  logic              rd, wr, enable, busy, hit, take, retire;
  logic [PRIO_W-1:0] mask;
  logic [ID_W-1:0]   busy_id;
  logic              unused_wdata;

  logic              irq_d, irq_q, ack_d, ack_q, eoi_d, eoi_q;
  logic [ID_W-1:0]   ack_id_d, ack_id_q, eoi_id_d, eoi_id_q;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  assign rd           = bus_en_i && !bus_we_i;
  assign wr           = bus_en_i && bus_we_i;
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:ID_W];

  cpuif_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl_i  (wr && bus_addr_i == SEL_CTRL),
    .wr_mask_i  (wr && bus_addr_i == SEL_MASK),
    .ctrl_bit_i (bus_wdata_i[0]),
    .mask_val_i (bus_wdata_i[PRIO_W-1:0]),
    .enable_o   (enable),
    .mask_o     (mask)
  );

  cpuif_qualify #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_qual (
    .enable_i     (enable),
    .busy_i       (busy),
    .cand_valid_i (cand_valid_i),
    .cand_id_i    (cand_id_i),
    .cand_prio_i  (cand_prio_i),
    .mask_i       (mask),
    .hit_o        (hit)
  );

  assign take = rd && bus_addr_i == SEL_ACK && hit;

  cpuif_active #(.ID_W(ID_W)) u_active (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take),
    .take_id_i (cand_id_i),
    .eoi_i     (wr && bus_addr_i == SEL_EOI),
    .eoi_id_i  (bus_wdata_i[ID_W-1:0]),
    .busy_o    (busy),
    .busy_id_o (busy_id),
    .retire_o  (retire)
  );

  always_comb begin
    irq_d    = hit && !take;
    ack_d    = take;
    ack_id_d = take ? cand_id_i : ack_id_q;
    eoi_d    = retire;
    eoi_id_d = retire ? busy_id : eoi_id_q;
    rdata_d  = rdata_q;
    if (rd) begin
      unique case (bus_addr_i)
        SEL_CTRL: rdata_d = DATA_W'(enable);
        SEL_MASK: rdata_d = DATA_W'(mask);
        SEL_ACK:  rdata_d = DATA_W'(hit ? cand_id_i : SPURIOUS);
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q    <= 1'b0;
      ack_q    <= 1'b0;
      ack_id_q <= '0;
      eoi_q    <= 1'b0;
      eoi_id_q <= '0;
      rdata_q  <= '0;
    end else begin
      irq_q    <= irq_d;
      ack_q    <= ack_d;
      ack_id_q <= ack_id_d;
      eoi_q    <= eoi_d;
      eoi_id_q <= eoi_id_d;
      rdata_q  <= rdata_d;
    end
  end

  assign irq_o        = irq_q;
  assign ack_strobe_o = ack_q;
  assign ack_id_o     = ack_id_q;
  assign eoi_strobe_o = eoi_q;
  assign eoi_id_o     = eoi_id_q;
  assign bus_rdata_o  = rdata_q;

  // R2: a request implies the enable bit was set
  a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(enable));

  // R3: a request implies the priority beat the threshold
  a_r3_below_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(cand_prio_i) < $past(mask)));

  // R5: the claim strobe agrees with the returned read data
  a_r5_rdata_match: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe_o |-> (bus_rdata_o == DATA_W'(ack_id_o)));

  // R7: reserved IDs are never claimed
  a_r7_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe_o |-> (ack_id_o < FIRST_RSVD));

  // R8: the request drops right after a claim
  a_r8_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !irq_o);
endmodule

// File: tb/test_cpuif_ack.sv
module test_cpuif_ack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid_i = 1'b0;
  logic [9:0]  cand_id_i = '0;
  logic [7:0]  cand_prio_i = '0;
  logic        bus_en_i = 1'b0;
  logic        bus_we_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, ack_strobe_o, eoi_strobe_o;
  logic [9:0]  ack_id_o, eoi_id_o;

  int vectors = 0;
  int miscompares = 0;
  bit compare_on = 1'b0;
  string cur_req = "R1";

  // reference state
  bit        m_en = 0;
  int        m_mask = 0;
  bit        m_busy = 0;
  int        m_bid = 0;
  bit        e_irq = 0;
  bit        e_ack = 0;
  bit        e_eoi = 0;
  int        e_ack_id = 0;
  int        e_eoi_id = 0;
  longint    e_rdata = 0;

  always #4 clk = ~clk;

  cpuif_ack i_cpuif_ack (
    .clk(clk), .rst_n(rst_n),
    .cand_valid_i(cand_valid_i), .cand_id_i(cand_id_i), .cand_prio_i(cand_prio_i),
    .bus_en_i(bus_en_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o),
    .ack_strobe_o(ack_strobe_o), .ack_id_o(ack_id_o),
    .eoi_strobe_o(eoi_strobe_o), .eoi_id_o(eoi_id_o)
  );

  always @(posedge clk) begin
    bit q;
    if (!rst_n) begin
      m_en = 0; m_mask = 0; m_busy = 0; m_bid = 0;
      e_irq = 0; e_ack = 0; e_eoi = 0; e_rdata = 0;
    end else begin
      q = m_en && cand_valid_i && (int'(cand_id_i) < 1020) &&
          (int'(cand_prio_i) < m_mask) && !m_busy;
      e_ack = 0;
      e_eoi = 0;
      e_irq = q;
      if (bus_en_i && !bus_we_i) begin
        case (bus_addr_i)
          2'd0: e_rdata = m_en;
          2'd1: e_rdata = m_mask;
          2'd2: begin
            e_rdata = q ? cand_id_i : 1023;
            if (q) begin
              e_irq = 0; e_ack = 1; e_ack_id = cand_id_i;
              m_busy = 1; m_bid = cand_id_i;
            end
          end
          default: e_rdata = 0;
        endcase
      end
      if (bus_en_i && bus_we_i) begin
        case (bus_addr_i)
          2'd0: m_en = bus_wdata_i[0];
          2'd1: m_mask = bus_wdata_i[7:0];
          2'd3: if (m_busy && int'(bus_wdata_i[9:0]) == m_bid) begin
            m_busy = 0; e_eoi = 1; e_eoi_id = m_bid;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      check("irq", irq_o, e_irq);
      check("rdata", bus_rdata_o, e_rdata);
      check("ack strobe", ack_strobe_o, e_ack);
      check("eoi strobe", eoi_strobe_o, e_eoi);
      if (e_ack) check("ack id", ack_id_o, e_ack_id);
      if (e_eoi) check("eoi id", eoi_id_o, e_eoi_id);
    end
  end

  task automatic access(bit we, int addr, int data);
    bus_en_i = 1; bus_we_i = we; bus_addr_i = 2'(addr); bus_wdata_i = 32'(data);
    @(negedge clk);
    bus_en_i = 0; bus_we_i = 0;
  endtask

  task automatic cand(bit v, int id, int prio);
    cand_valid_i = v; cand_id_i = 10'(id); cand_prio_i = 8'(prio);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    // R1: outputs at reset
    cur_req = "R1";
    check("reset irq", irq_o, 0);
    check("reset rdata", bus_rdata_o, 0);
    check("reset ack", ack_strobe_o, 0);
    check("reset eoi", eoi_strobe_o, 0);
    idle(2);
    rst_n = 1;
    compare_on = 1;
    idle(1);

    cur_req = "R11";
    access(1, 1, 32'h1F0);
    access(1, 0, 32'hFFFF_FFFF);
    access(0, 0, 0);
    access(0, 1, 0);
    access(0, 3, 0);
    idle(1);

    cur_req = "R2";
    cand(1, 40, 8'hA0);
    idle(3);

    cur_req = "R5";
    access(0, 2, 0);
    cur_req = "R8";
    idle(4);

    cur_req = "R10";
    access(1, 3, 41);
    idle(2);
    access(0, 2, 0);
    idle(1);

    cur_req = "R9";
    access(1, 3, 32'hFC00_0000 | 40);
    idle(3);
    access(0, 2, 0);
    access(1, 3, 40);
    idle(1);

    cur_req = "R3";
    cand(1, 70, 8'hF0);
    idle(2);
    cand(1, 70, 8'hFF);
    idle(2);
    cur_req = "R6";
    access(0, 2, 0);
    access(1, 3, 70);
    idle(1);

    cur_req = "R7";
    cand(1, 1020, 0);
    idle(2);
    access(0, 2, 0);
    cand(1, 1023, 0);
    idle(2);
    access(0, 2, 0);

    cur_req = "R4";
    access(1, 0, 0);
    cand(1, 50, 8'h10);
    idle(2);
    access(0, 2, 0);
    access(1, 0, 1);
    idle(2);

    cur_req = "R9";
    cand(1, 60, 8'h20);
    access(0, 2, 0);
    idle(1);
    cand(1, 61, 8'h20);
    access(1, 3, 60);
    idle(3);

    cur_req = "R3";
    access(1, 1, 8'h20);
    idle(2);
    access(1, 1, 8'h21);
    idle(2);
    cand(0, 0, 0);
    idle(2);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule